// File: doc/BRIEF.md
# Configurable PLD Output Cell

This block is one output cell of a small sum-of-products programmable logic device. It takes eight product-term results from the AND array. It reduces them with an OR to a single sum and applies a programmable polarity. Depending on the configuration, the cell either stores that value in a flip-flop or passes it straight to the pin. It drives the pin value and the pin tri-state enable, and it returns a feedback bit to the array.

Two global mode bits are shared by every cell of the device and choose one of three modes: registered, complex or simple. Two per-cell bits choose the polarity and the cell's role within the mode. The output enable can come from three sources: a shared active-low enable pin, the cell's first product term, or a fixed on/off setting. The register is cleared at power-up by a synchronous active-low reset. A synchronous test preload can force the register to any value, so that illegal states can be loaded before the logic is sequenced.

Top module: `pld_out_cell`

## Requirements
- R1: With gmode_a=0 and gmode_b=1 (registered mode) and cell_dir=0, the cell is a registered output. On each rising edge, with no reset and no preload, the register captures the OR of all eight terms after polarity. One edge later, pin_out equals cell_pol ? OR(terms) : ~OR(terms).
- R2: In the registered-output configuration of R1, pin_oe equals the inverse of the shared active-low oe_n input.
- R3: In registered mode with cell_dir=1, and in complex mode (gmode_a=1, gmode_b=1) for either cell_dir, the cell is combinational. pin_out is the polarity-applied OR of terms[7:1]. pin_oe equals terms[0]. fb_out is pin_out when pin_oe=1 and pin_in otherwise.
- R4: In simple mode (gmode_a=1, gmode_b=0), cell_dir=0 gives pin_oe=1 and pin_out equal to the polarity-applied OR of all eight terms. cell_dir=1 gives pin_oe=0 and fb_out=pin_in.
- R5: cell_pol=1 gives an active-high output and cell_pol=0 an active-low output, in every mode.
- R6: The reserved setting gmode_a=0, gmode_b=0 turns the driver off (pin_oe=0) and makes fb_out follow pin_in.
- R7: While rst_n=0 at a rising edge, the register is cleared to 0. A registered output then shows fb_out=0 and pin_out=1 for either polarity.
- R8: Preload (pre_en=1 at a rising edge) loads pre_val into the register in place of the captured sum. Reset takes priority over preload. The pin then shows the inverse of the loaded value.
- R9: In the registered-output configuration, fb_out is the true register value, which is the inverse of pin_out, whatever oe_n is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock, rising edge |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| terms | input | 8 | Product-term results from the AND array; bit 0 is the enable term |
| oe_n | input | 1 | Shared active-low output enable pin |
| gmode_a | input | 1 | Global mode bit A (0 selects registered mode) |
| gmode_b | input | 1 | Global mode bit B |
| cell_dir | input | 1 | Per-cell role select within the mode |
| cell_pol | input | 1 | Per-cell polarity, 1 = active high |
| pre_en | input | 1 | Synchronous test preload strobe |
| pre_val | input | 1 | Register value to preload |
| pin_in | input | 1 | Value seen on the pad when the driver is off |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback bit to the AND array |

## Verification
The assertions assume that the configuration bits do not change in the cycle between a reset or preload edge and the cycle in which the register is observed. The stimulus changes mode and cell bits only at falling edges. Inputs are drawn at random with a fixed seed and held for a whole clock period. Every global mode is covered, including the reserved one. Directed cases add reset combined with preload, preload of both values, and a registered pin observed under both polarities.

// File: rtl/pld_cell_pkg.sv
// Shared types for the PLD output cell.
// Assumes one cell per instance; the global mode bits are identical across cells.
package pld_cell_pkg;

    typedef enum logic [1:0] {
        CM_REG = 2'd0,
        CM_CPX = 2'd1,
        CM_SMP = 2'd2,
        CM_RSV = 2'd3
    } cell_mode_e;

    // Decoded control for one cell
    typedef struct packed {
        logic reg_out;    // registered output drives pin and feedback
        logic oe_pin;     // enable from shared pin
        logic oe_term;    // enable from the cell's enable term
        logic oe_on;      // fixed enable when no other source applies
        logic all_terms;  // combinational sum uses every term
    } cell_ctl_t;

    function automatic cell_mode_e decode_mode(input logic a, input logic b);
        if (!a && b)      return CM_REG;
        else if (a && b)  return CM_CPX;
        else if (a && !b) return CM_SMP;
        else              return CM_RSV;
    endfunction

endpackage

// File: rtl/cell_mode_dec.sv
// Mode decoder: turns the global and per-cell configuration into cell controls.
// Assumes configuration is static during normal operation.
module cell_mode_dec
    import pld_cell_pkg::*;
(
    input  logic      gmode_a,
    input  logic      gmode_b,
    input  logic      cell_dir,
    output cell_ctl_t ctl
);
    cell_mode_e mode;

    // Map mode and role to output source and enable source
    always_comb begin
        mode          = decode_mode(gmode_a, gmode_b);
        ctl           = '0;
        ctl.all_terms = 1'b1;
        unique case (mode)
            CM_REG: begin
                ctl.reg_out   = !cell_dir;
                ctl.oe_pin    = !cell_dir;
                ctl.oe_term   = cell_dir;
                ctl.all_terms = !cell_dir;
            end
            CM_CPX: begin
                ctl.oe_term   = 1'b1;
                ctl.all_terms = 1'b0;
            end
            CM_SMP: begin
                ctl.oe_on     = !cell_dir;
            end
            default: begin
                ctl.oe_on     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pterm_sum.sv
// Product-term OR reduction: full sum, sum without the enable term, and the enable term.
// Assumes OE_IDX is a valid term index.
module pterm_sum #(
    parameter int NTERM  = 8,
    parameter int OE_IDX = 0
) (
    input  logic [NTERM-1:0] terms,
    output logic             sum_all,
    output logic             sum_logic,
    output logic             oe_term
);
    logic [NTERM-1:0] logic_terms;

    // Mask out the enable term from the logic sum
    for (genvar g = 0; g < NTERM; g++) begin : g_mask
        if (g == OE_IDX) begin : g_oe
            assign logic_terms[g] = 1'b0;
        end else begin : g_lg
            assign logic_terms[g] = terms[g];
        end
    end

    // Reductions
    always_comb begin
        sum_all   = |terms;
        sum_logic = |logic_terms;
        oe_term   = terms[OE_IDX];
    end
endmodule

// File: rtl/cell_state_reg.sv
// Cell flip-flop with synchronous clear and synchronous test preload.
// Assumes reset outranks preload, which outranks normal capture.
module cell_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_en,
    input  logic pre_val,
    input  logic d,
    output logic q
);
    // Rising-edge update with priority clear > preload > capture
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (pre_en) q <= pre_val;
        else             q <= d;
    end
endmodule

// File: rtl/pld_out_cell.sv
// PLD output cell top: combines term sums, polarity, register and enable selection.
// Assumes the pin reads the inverse of the register so a cleared register shows high.
module pld_out_cell
    import pld_cell_pkg::*;
#(
    parameter int NTERM = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTERM-1:0] terms,
    input  logic             oe_n,
    input  logic             gmode_a,
    input  logic             gmode_b,
    input  logic             cell_dir,
    input  logic             cell_pol,
    input  logic             pre_en,
    input  logic             pre_val,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb_out
);
    localparam int OE_IDX = 0;

    cell_ctl_t ctl;
    logic      sum_all, sum_logic, oe_term;
    logic      d, q, comb_sum, comb_val;

    cell_mode_dec u_dec (
        .gmode_a (gmode_a),
        .gmode_b (gmode_b),
        .cell_dir(cell_dir),
        .ctl     (ctl)
    );

    pterm_sum #(.NTERM(NTERM), .OE_IDX(OE_IDX)) u_sum (
        .terms    (terms),
        .sum_all  (sum_all),
        .sum_logic(sum_logic),
        .oe_term  (oe_term)
    );

    cell_state_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .pre_en (pre_en),
        .pre_val(pre_val),
        .d      (d),
        .q      (q)
    );

    // Register input stores the complement of the wanted pin level
    always_comb d = cell_pol ? !sum_all : sum_all;

    // Combinational path with polarity
    always_comb begin
        comb_sum = ctl.all_terms ? sum_all : sum_logic;
        comb_val = cell_pol ? comb_sum : !comb_sum;
    end

    // Pin value, enable and feedback selection
    always_comb begin
        pin_out = ctl.reg_out ? !q : comb_val;
        if (ctl.oe_pin)       pin_oe = !oe_n;
        else if (ctl.oe_term) pin_oe = oe_term;
        else                  pin_oe = ctl.oe_on;
        fb_out  = ctl.reg_out ? q : (pin_oe ? pin_out : pin_in);
    end
endmodule

// File: rtl/pld_out_cell_chk.sv
// Assertion checker for pld_out_cell, attached by bind; observes ports only.
// Assumes configuration inputs are held for a full clock period.
module pld_out_cell_chk #(
    parameter int NTERM = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NTERM-1:0] terms,
    input logic             oe_n,
    input logic             gmode_a,
    input logic             gmode_b,
    input logic             cell_dir,
    input logic             cell_pol,
    input logic             pre_en,
    input logic             pre_val,
    input logic             pin_in,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             fb_out
);
    logic reg_cell, io_cell, smp_mode, rsv_mode;

    // Configuration classes seen at the ports
    always_comb begin
        reg_cell = !gmode_a && gmode_b && !cell_dir;
        io_cell  = (!gmode_a && gmode_b && cell_dir) || (gmode_a && gmode_b);
        smp_mode = gmode_a && !gmode_b;
        rsv_mode = !gmode_a && !gmode_b;
    end

    p_reg_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cell |-> (pin_oe == !oe_n));

    p_io_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_cell |-> (pin_oe == terms[0]));

    p_io_fb_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cell && !pin_oe) |-> (fb_out == pin_in));

    p_simple_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_mode |-> (pin_oe == !cell_dir));

    p_simple_pol_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_mode && !cell_dir) |-> (pin_out == (cell_pol ? |terms : ~|terms)));

    p_reserved_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_mode |-> (!pin_oe && fb_out == pin_in));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!reg_cell || (fb_out == 1'b0 && pin_out == 1'b1)));

    p_preload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> (!reg_cell || fb_out == $past(pre_val)));

    p_reg_fb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cell |-> (fb_out == !pin_out));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NTERM(NTERM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .terms   (terms),
    .oe_n    (oe_n),
    .gmode_a (gmode_a),
    .gmode_b (gmode_b),
    .cell_dir(cell_dir),
    .cell_pol(cell_pol),
    .pre_en  (pre_en),
    .pre_val (pre_val),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb_out  (fb_out)
);

// File: tb/test_pld_out_cell.sv
// Self-checking bench for pld_out_cell: seeded random plus directed corners.
module test_pld_out_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] terms = '0;
    logic       oe_n = 1'b0, gmode_a = 1'b0, gmode_b = 1'b1, cell_dir = 1'b0;
    logic       cell_pol = 1'b1, pre_en = 1'b0, pre_val = 1'b0, pin_in = 1'b0;
    logic       pin_out, pin_oe, fb_out;

    int  n_chk = 0;
    int  n_fail = 0;
    logic mq = 1'b0;   // bench model of the register

    pld_out_cell i_pld_out_cell (
        .clk(clk), .rst_n(rst_n), .terms(terms), .oe_n(oe_n),
        .gmode_a(gmode_a), .gmode_b(gmode_b), .cell_dir(cell_dir),
        .cell_pol(cell_pol), .pre_en(pre_en), .pre_val(pre_val),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    always #10 clk = ~clk;

    // Expected values from the requirements
    function automatic logic is_reg_cell();
        return !gmode_a && gmode_b && !cell_dir;
    endfunction
    function automatic logic is_io_cell();
        return (!gmode_a && gmode_b && cell_dir) || (gmode_a && gmode_b);
    endfunction
    function automatic logic e_oe();
        if (is_reg_cell()) return !oe_n;                 // R2
        if (is_io_cell())  return terms[0];              // R3
        if (gmode_a && !gmode_b) return !cell_dir;       // R4
        return 1'b0;                                      // R6
    endfunction
    function automatic logic e_out();
        logic s;
        if (is_reg_cell()) return !mq;                   // R1, R7, R8
        s = is_io_cell() ? |terms[7:1] : |terms;
        return cell_pol ? s : !s;                        // R5
    endfunction
    function automatic logic e_fb();
        if (is_reg_cell()) return mq;                    // R9
        return e_oe() ? e_out() : pin_in;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b (mode=%b%b dir=%b pol=%b terms=%h)",
                     tag, act, exp, gmode_a, gmode_b, cell_dir, cell_pol, terms);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " pin_oe"},  pin_oe,  e_oe());
        if (e_oe() || is_reg_cell()) chk({tag, " pin_out"}, pin_out, e_out());
        chk({tag, " fb_out"},  fb_out,  e_fb());
    endtask

    // Hold inputs for one period: check, then model the rising edge
    task automatic step(input string tag);
        #2 check_all(tag);
        @(posedge clk);
        if (!rst_n)      mq = 1'b0;
        else if (pre_en) mq = pre_val;
        else             mq = cell_pol ? !(|terms) : |terms;
        @(negedge clk);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = $urandom(32'd4711);
        @(negedge clk);
        // R7: reset state with preload asserted, both polarities
        rst_n = 0; pre_en = 1; pre_val = 1; terms = 8'hFF;
        cell_pol = 1; step("R7 reset pol1");
        cell_pol = 0; step("R7 reset pol0");
        #2 chk("R7 pin high after reset", pin_out, 1'b1);
        chk("R7 fb zero after reset", fb_out, 1'b0);
        rst_n = 1; pre_en = 0;
        // R8: preload both values
        pre_en = 1; pre_val = 1; step("R8 preload 1");
        #2 chk("R8 fb after preload 1", fb_out, 1'b1);
        chk("R8 pin after preload 1", pin_out, 1'b0);
        pre_val = 0; step("R8 preload 0");
        pre_en = 0;
        // R1: registered capture, R2 shared enable off
        terms = 8'h00; cell_pol = 1; oe_n = 1; step("R1 capture zero");
        #2 chk("R1 pin after zero sum", pin_out, 1'b0);
        chk("R2 enable off", pin_oe, 1'b0);
        terms = 8'h01; step("R1 single term");
        #2 chk("R1 pin after set sum", pin_out, 1'b1);
        // R3: enable term only, logic sum zero
        cell_dir = 1; terms = 8'h01; pin_in = 0; step("R3 oe term only");
        terms = 8'h80; pin_in = 1; step("R3 driver off");
        // R6 reserved, R4 simple input
        gmode_a = 0; gmode_b = 0; step("R6 reserved");
        gmode_a = 1; cell_dir = 1; step("R4 simple input");
        cell_dir = 0; cell_pol = 0; step("R4 R5 simple active low");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            terms    = $urandom;
            gmode_a  = r[0]; gmode_b = r[1]; cell_dir = r[2]; cell_pol = r[3];
            oe_n     = r[4]; pin_in = r[5]; pre_val = r[6];
            pre_en   = (r[11:8] == 4'd0);
            rst_n    = (r[17:12] != 6'd0);
            if (r[20:18] == 3'd0) terms = 8'h00;
            step("R1-R9 random");
        end
        rst_n = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule